// File: doc/BRIEF.md
# Interlaced 625-Line Raster Sync Timing Generator

This block derives every timing signal of a 625-line interlaced raster from one clock running at four times the colour subcarrier frequency. A horizontal counter walks the clock positions of a line and a line counter walks the frame. A small state machine tracks which kind of line is current. An output stage turns that line kind and the clock position into the following signals:

- an active-low composite sync carrying normal, equalising and broad pulses
- an active-low vertical-interval flag
- an active-low back-porch window
- an active-picture window
- a field-parity flag

All five outputs are registered. They leave together with a copy of the line number and clock position they belong to, so downstream pixel logic can key colour patterns to the exported position without any skew.

The line-kind state machine has nine states:

| State | Lines | Sync content |
|---|---|---|
| `LK_BLANK` | 5-21, 318-334 | normal sync, no picture |
| `LK_PIC_LATE` | 22 | normal sync, picture only in the second half |
| `LK_PICTURE` | 23-309, 335-621 | normal sync, full picture |
| `LK_PIC_EARLY` | 622 | picture only in the first half, equalising pulse at mid-line |
| `LK_EQ_EQ` | 3-4, 310-311, 315-316, 623-624 | two equalising pulses |
| `LK_EQ_BROAD` | 312 | equalising pulse, then a broad pulse at mid-line |
| `LK_BROAD_BROAD` | 0-1, 313-314 | two broad pulses |
| `LK_BROAD_EQ` | 2 | broad pulse, then an equalising pulse at mid-line |
| `LK_EQ_NONE` | 317 | one equalising pulse, empty second half |

Transitions happen only on the last clock of a line, and each is chosen by the number of the line that is ending:

- `LK_BLANK` goes to `LK_PIC_LATE` after line 21 and to `LK_PICTURE` after line 334.
- `LK_PIC_LATE` goes to `LK_PICTURE`.
- `LK_PICTURE` goes to `LK_EQ_EQ` after line 309 and to `LK_PIC_EARLY` after line 621.
- `LK_PIC_EARLY` goes to `LK_EQ_EQ`.
- `LK_EQ_EQ` goes to `LK_EQ_BROAD` after line 311, to `LK_EQ_NONE` after 316, to `LK_BROAD_BROAD` after 624 and to `LK_BLANK` after 4.
- `LK_EQ_BROAD` goes to `LK_BROAD_BROAD`.
- `LK_BROAD_BROAD` goes to `LK_EQ_EQ` after 314 and to `LK_BROAD_EQ` after 1.
- `LK_BROAD_EQ` goes to `LK_EQ_EQ`.
- `LK_EQ_NONE` goes to `LK_BLANK`.

Reset enters `LK_BLANK`.

Top module: `pal_sync_gen`

## Requirements
Default clock positions are used below. Each is a parameter: line length 1135, mid-line 568, normal sync 86, equalising 38, broad 533, picture 188 to 1109, late start 581, early end 560.

- R1: `hpos` counts 0 to 1134 and wraps to 0. `line_no` increments on each wrap and goes from 624 to 0. The two exported values always advance together, one clock at a time.
- R2: Synchronous reset shows line 5, clock 0, `csync_n`=1, `vint_n`=1, `porch_n`=1, `pic_active`=0 and `odd_field`=1 while held. The first output after release is line 5, clock 0 with `csync_n`=0.
- R3: On lines 5-309 and 318-621, `csync_n` is 0 exactly for clocks 0-85.
- R4: On lines 5-309 and 318-622, `porch_n` is 0 for clocks 86-187. It is 1 at every other position and on every other line.
- R5: `pic_active` is 1 for clocks 188-1109 on lines 23-309 and 335-621, and 0 on blanked lines.
- R6: On line 22, `pic_active` is 1 only for clocks 581-1109. On line 622, it is 1 only for clocks 188-559; that line has normal sync plus an equalising pulse, with `csync_n` 0 for clocks 568-605.
- R7: An equalising pulse holds `csync_n` at 0 for 38 clocks from clock 0 or from clock 568. Lines 3, 4, 310, 311, 315, 316, 623 and 624 carry both. Line 317 carries only the first.
- R8: A broad pulse holds `csync_n` at 0 for 533 clocks from clock 0 or clock 568. Lines 0, 1, 313 and 314 carry both. Line 312 has an equalising pulse, then a broad pulse at 568. Line 2 has a broad pulse, then an equalising pulse at 568.
- R9: `vint_n` is 0 from line 312 clock 568 through the end of line 314, and from line 0 clock 0 until line 2 clock 532. It is 1 everywhere else.
- R10: `odd_field` is 1 on lines 0-312 and 0 on lines 313-624. It rises only when the line number wraps to 0.
- R11: `pic_active` is 0 on every equalising or broad-pulse line (0-4 and 310-317, 623-624).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raster clock, four times the subcarrier |
| rst | input | 1 | Synchronous reset, active high |
| csync_n | output | 1 | Composite sync, active low |
| vint_n | output | 1 | Vertical-interval flag, active low |
| porch_n | output | 1 | Back-porch window, active low |
| pic_active | output | 1 | Active-picture window |
| odd_field | output | 1 | Field parity flag |
| line_no | output | 10 | Line number belonging to the outputs |
| hpos | output | HPOS_W | Clock position belonging to the outputs |

## Verification
The block has no data input, so the stimulus patterns are a reset from power-up, a free run through every line of both fields including the wrap from 624 to 0, and a reset asserted in the middle of a line. The free run exercises every line kind in turn. It separates normal, equalising and broad pulses by their widths and their mid-line placement, and separates the two half-picture lines from full picture lines by their window edges. The mid-line reset shows that restart lands at line 5, clock 0 from any position, and not only from the power-up state. The bench uses a shortened line with scaled positions, so that a whole frame fits in the run while the line sequence stays the real 625-line one.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

    localparam int LINE_W = 10;

    // frame structure (fixed by the 625-line raster)
    localparam logic [LINE_W-1:0] LN_LAST         = 10'd624;
    localparam logic [LINE_W-1:0] LN_START        = 10'd5;
    localparam logic [LINE_W-1:0] LN_BLANK_A_END  = 10'd21;
    localparam logic [LINE_W-1:0] LN_PIC_A_END    = 10'd309;
    localparam logic [LINE_W-1:0] LN_EQ_PRE_A_END = 10'd311;
    localparam logic [LINE_W-1:0] LN_FIELD_FLIP   = 10'd312;
    localparam logic [LINE_W-1:0] LN_BROAD_A_END  = 10'd314;
    localparam logic [LINE_W-1:0] LN_EQ_POST_A    = 10'd316;
    localparam logic [LINE_W-1:0] LN_BLANK_B_END  = 10'd334;
    localparam logic [LINE_W-1:0] LN_PIC_B_END    = 10'd621;
    localparam logic [LINE_W-1:0] LN_BROAD_B_END  = 10'd1;
    localparam logic [LINE_W-1:0] LN_EQ_POST_B    = 10'd4;

    typedef enum logic [3:0] {
        LK_BLANK,
        LK_PICTURE,
        LK_PIC_LATE,
        LK_PIC_EARLY,
        LK_EQ_EQ,
        LK_EQ_BROAD,
        LK_BROAD_BROAD,
        LK_BROAD_EQ,
        LK_EQ_NONE
    } line_kind_t;

endpackage

// File: rtl/pal_raster_counter.sv
module pal_raster_counter
    import pal_sync_pkg::*;
#(
    parameter int CLKS_PER_LINE = 1135,
    parameter int HPOS_W        = $clog2(CLKS_PER_LINE)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [HPOS_W-1:0] hcnt,
    output logic [LINE_W-1:0] vcnt,
    output logic              line_end
);

    localparam logic [HPOS_W-1:0] H_LAST = HPOS_W'(CLKS_PER_LINE - 1);

    assign line_end = (hcnt == H_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= LN_START;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= (vcnt == LN_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // R1: position never leaves the line
    p_hpos_bound_r1: assert property (@(posedge clk) disable iff (rst)
        hcnt <= H_LAST);

    // R1: wrap of clock position
    p_hpos_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        line_end |=> hcnt == '0);

    // R1: frame wrap
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (line_end && vcnt == LN_LAST) |=> vcnt == '0);

    // R1: line number only moves at the end of a line
    p_line_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(vcnt));

endmodule

// File: rtl/pal_line_fsm.sv
module pal_line_fsm
    import pal_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [LINE_W-1:0] vcnt,
    output line_kind_t        kind,
    output logic              field_flag
);

    line_kind_t kind_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= LK_BLANK;
        end else if (line_end) begin
            kind <= kind_d;
        end
    end

    // transitions, chosen by the number of the line that is ending
    always_comb begin
        kind_d = kind;
        unique case (kind)
            LK_BLANK: begin
                if (vcnt == LN_BLANK_A_END) begin
                    kind_d = LK_PIC_LATE;
                end else if (vcnt == LN_BLANK_B_END) begin
                    kind_d = LK_PICTURE;
                end
            end
            LK_PIC_LATE: kind_d = LK_PICTURE;
            LK_PICTURE: begin
                if (vcnt == LN_PIC_A_END) begin
                    kind_d = LK_EQ_EQ;
                end else if (vcnt == LN_PIC_B_END) begin
                    kind_d = LK_PIC_EARLY;
                end
            end
            LK_PIC_EARLY: kind_d = LK_EQ_EQ;
            LK_EQ_EQ: begin
                if (vcnt == LN_EQ_PRE_A_END) begin
                    kind_d = LK_EQ_BROAD;
                end else if (vcnt == LN_EQ_POST_A) begin
                    kind_d = LK_EQ_NONE;
                end else if (vcnt == LN_LAST) begin
                    kind_d = LK_BROAD_BROAD;
                end else if (vcnt == LN_EQ_POST_B) begin
                    kind_d = LK_BLANK;
                end
            end
            LK_EQ_BROAD: kind_d = LK_BROAD_BROAD;
            LK_BROAD_BROAD: begin
                if (vcnt == LN_BROAD_A_END) begin
                    kind_d = LK_EQ_EQ;
                end else if (vcnt == LN_BROAD_B_END) begin
                    kind_d = LK_BROAD_EQ;
                end
            end
            LK_BROAD_EQ: kind_d = LK_EQ_EQ;
            LK_EQ_NONE:  kind_d = LK_BLANK;
            default:     kind_d = LK_BLANK;
        endcase
    end

    // field parity follows the line number at the line boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            field_flag <= 1'b1;
        end else if (line_end) begin
            if (vcnt == LN_LAST) begin
                field_flag <= 1'b1;
            end else if (vcnt == LN_FIELD_FLIP) begin
                field_flag <= 1'b0;
            end
        end
    end

    // R10: parity rises only at the frame wrap
    p_field_set_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(field_flag) |-> vcnt == '0);

    // R10: parity falls only entering the second field
    p_field_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(field_flag) |-> vcnt == LN_FIELD_FLIP + 1'b1);

    // R8: broad-pulse lines appear only at the two vertical intervals
    p_broad_lines_r8: assert property (@(posedge clk) disable iff (rst)
        (kind == LK_BROAD_BROAD) |-> (vcnt <= LN_BROAD_B_END ||
                                      (vcnt > LN_FIELD_FLIP && vcnt <= LN_BROAD_A_END)));

endmodule

// File: rtl/pal_pulse_shaper.sv
module pal_pulse_shaper
    import pal_sync_pkg::*;
#(
    parameter int HPOS_W     = 11,
    parameter int MID_POS    = 568,
    parameter int HSYNC_LEN  = 86,
    parameter int EQ_LEN     = 38,
    parameter int BROAD_LEN  = 533,
    parameter int PIC_START  = 188,
    parameter int PIC_END    = 1110,
    parameter int LATE_START = 581,
    parameter int EARLY_END  = 560
) (
    input  logic              clk,
    input  logic              rst,
    input  line_kind_t        kind,
    input  logic [HPOS_W-1:0] hcnt,
    input  logic [LINE_W-1:0] vcnt,
    input  logic              field_flag,
    output logic              csync_n,
    output logic              vint_n,
    output logic              porch_n,
    output logic              pic_active,
    output logic              odd_field,
    output logic [LINE_W-1:0] line_q,
    output logic [HPOS_W-1:0] hpos_q
);

    localparam logic [HPOS_W-1:0] P_MID    = HPOS_W'(MID_POS);
    localparam logic [HPOS_W-1:0] P_HS     = HPOS_W'(HSYNC_LEN);
    localparam logic [HPOS_W-1:0] P_EQ     = HPOS_W'(EQ_LEN);
    localparam logic [HPOS_W-1:0] P_BR     = HPOS_W'(BROAD_LEN);
    localparam logic [HPOS_W-1:0] P_MID_EQ = HPOS_W'(MID_POS + EQ_LEN);
    localparam logic [HPOS_W-1:0] P_MID_BR = HPOS_W'(MID_POS + BROAD_LEN);
    localparam logic [HPOS_W-1:0] P_PS     = HPOS_W'(PIC_START);
    localparam logic [HPOS_W-1:0] P_PE     = HPOS_W'(PIC_END);
    localparam logic [HPOS_W-1:0] P_LATE   = HPOS_W'(LATE_START);
    localparam logic [HPOS_W-1:0] P_EARLY  = HPOS_W'(EARLY_END);

    logic lead_hs, lead_eq, lead_br, mid_eq, mid_br, second_half;
    logic porch_win, pic_full, pic_late, pic_early;
    logic sync_lo, porch_lo, act_hi, vint_lo;

    assign lead_hs     = hcnt < P_HS;
    assign lead_eq     = hcnt < P_EQ;
    assign lead_br     = hcnt < P_BR;
    assign second_half = hcnt >= P_MID;
    assign mid_eq      = second_half && (hcnt < P_MID_EQ);
    assign mid_br      = second_half && (hcnt < P_MID_BR);
    assign porch_win   = (hcnt >= P_HS) && (hcnt < P_PS);
    assign pic_full    = (hcnt >= P_PS) && (hcnt < P_PE);
    assign pic_late    = (hcnt >= P_LATE) && (hcnt < P_PE);
    assign pic_early   = (hcnt >= P_PS) && (hcnt < P_EARLY);

    // output decode per line kind
    always_comb begin
        sync_lo  = 1'b0;
        porch_lo = 1'b0;
        act_hi   = 1'b0;
        vint_lo  = 1'b0;
        unique case (kind)
            LK_BLANK: begin
                sync_lo  = lead_hs;
                porch_lo = porch_win;
            end
            LK_PICTURE: begin
                sync_lo  = lead_hs;
                porch_lo = porch_win;
                act_hi   = pic_full;
            end
            LK_PIC_LATE: begin
                sync_lo  = lead_hs;
                porch_lo = porch_win;
                act_hi   = pic_late;
            end
            LK_PIC_EARLY: begin
                sync_lo  = lead_hs || mid_eq;
                porch_lo = porch_win;
                act_hi   = pic_early;
            end
            LK_EQ_EQ:       sync_lo = lead_eq || mid_eq;
            LK_EQ_BROAD: begin
                sync_lo = lead_eq || mid_br;
                vint_lo = second_half;
            end
            LK_BROAD_BROAD: begin
                sync_lo = lead_br || mid_br;
                vint_lo = 1'b1;
            end
            LK_BROAD_EQ: begin
                sync_lo = lead_br || mid_eq;
                vint_lo = lead_br;
            end
            LK_EQ_NONE:     sync_lo = lead_eq;
            default: begin
                sync_lo = 1'b0;
            end
        endcase
    end

    // output register stage, position copies kept aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            csync_n    <= 1'b1;
            vint_n     <= 1'b1;
            porch_n    <= 1'b1;
            pic_active <= 1'b0;
            odd_field  <= 1'b1;
            line_q     <= LN_START;
            hpos_q     <= '0;
        end else begin
            csync_n    <= ~sync_lo;
            vint_n     <= ~vint_lo;
            porch_n    <= ~porch_lo;
            pic_active <= act_hi;
            odd_field  <= field_flag;
            line_q     <= vcnt;
            hpos_q     <= hcnt;
        end
    end

    // R11: picture forced black throughout the vertical interval
    p_black_vint_r11: assert property (@(posedge clk) disable iff (rst)
        !vint_n |-> !pic_active);

    // R4: back porch never overlaps a sync pulse
    p_porch_after_sync_r4: assert property (@(posedge clk) disable iff (rst)
        !porch_n |-> csync_n);

    // R5: picture never overlaps sync or porch
    p_pic_clear_r5: assert property (@(posedge clk) disable iff (rst)
        pic_active |-> (csync_n && porch_n));

    // R9: vertical flag only on broad-pulse bearing lines
    p_vint_kind_r9: assert property (@(posedge clk) disable iff (rst)
        (kind == LK_EQ_EQ || kind == LK_BLANK || kind == LK_PICTURE) |=> vint_n);

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
    import pal_sync_pkg::*;
#(
    parameter int CLKS_PER_LINE = 1135,
    parameter int MID_POS       = 568,
    parameter int HSYNC_LEN     = 86,
    parameter int EQ_LEN        = 38,
    parameter int BROAD_LEN     = 533,
    parameter int PIC_START     = 188,
    parameter int PIC_END       = 1110,
    parameter int LATE_START    = 581,
    parameter int EARLY_END     = 560,
    parameter int HPOS_W        = $clog2(CLKS_PER_LINE)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              csync_n,
    output logic              vint_n,
    output logic              porch_n,
    output logic              pic_active,
    output logic              odd_field,
    output logic [9:0]        line_no,
    output logic [HPOS_W-1:0] hpos
);

    logic [HPOS_W-1:0] hcnt;
    logic [LINE_W-1:0] vcnt;
    logic              line_end;
    line_kind_t        kind;
    logic              field_flag;

    pal_raster_counter #(
        .CLKS_PER_LINE (CLKS_PER_LINE),
        .HPOS_W        (HPOS_W)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .line_end (line_end)
    );

    pal_line_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_end),
        .vcnt       (vcnt),
        .kind       (kind),
        .field_flag (field_flag)
    );

    pal_pulse_shaper #(
        .HPOS_W     (HPOS_W),
        .MID_POS    (MID_POS),
        .HSYNC_LEN  (HSYNC_LEN),
        .EQ_LEN     (EQ_LEN),
        .BROAD_LEN  (BROAD_LEN),
        .PIC_START  (PIC_START),
        .PIC_END    (PIC_END),
        .LATE_START (LATE_START),
        .EARLY_END  (EARLY_END)
    ) u_shaper (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .field_flag (field_flag),
        .csync_n    (csync_n),
        .vint_n     (vint_n),
        .porch_n    (porch_n),
        .pic_active (pic_active),
        .odd_field  (odd_field),
        .line_q     (line_no),
        .hpos_q     (hpos)
    );

endmodule

// File: tb/test_pal_sync_gen.sv
module test_pal_sync_gen;

    // shortened line with scaled positions; line sequence stays 625
    localparam int L     = 200;
    localparam int MID   = 100;
    localparam int HS    = 15;
    localparam int EQ    = 7;
    localparam int BR    = 90;
    localparam int PS    = 33;
    localparam int PE    = 195;
    localparam int LATE  = 102;
    localparam int EARLY = 98;
    localparam int HW    = $clog2(L);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csync_n, vint_n, porch_n, pic_active, odd_field;
    logic [9:0]    line_no;
    logic [HW-1:0] hpos;

    int n_checks = 0;
    int n_errors = 0;
    int prev_line = 0;
    int prev_h = 0;
    bit prev_ok = 1'b0;

    always #2 clk = ~clk;

    pal_sync_gen #(
        .CLKS_PER_LINE (L),
        .MID_POS       (MID),
        .HSYNC_LEN     (HS),
        .EQ_LEN        (EQ),
        .BROAD_LEN     (BR),
        .PIC_START     (PS),
        .PIC_END       (PE),
        .LATE_START    (LATE),
        .EARLY_END     (EARLY)
    ) i_pal_sync_gen (
        .clk        (clk),
        .rst        (rst),
        .csync_n    (csync_n),
        .vint_n     (vint_n),
        .porch_n    (porch_n),
        .pic_active (pic_active),
        .odd_field  (odd_field),
        .line_no    (line_no),
        .hpos       (hpos)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (line %0d clock %0d)",
                     req, what, act, exp, line_no, hpos);
        end
    endtask

    // 0 blank, 1 picture, 2 late half, 3 early half, 4 eq+eq,
    // 5 eq+broad, 6 broad+broad, 7 broad+eq, 8 eq only
    function automatic int kind_of(input int ln);
        if (ln <= 1) return 6;
        if (ln == 2) return 7;
        if (ln <= 4) return 4;
        if (ln <= 21) return 0;
        if (ln == 22) return 2;
        if (ln <= 309) return 1;
        if (ln <= 311) return 4;
        if (ln == 312) return 5;
        if (ln <= 314) return 6;
        if (ln <= 316) return 4;
        if (ln == 317) return 8;
        if (ln <= 334) return 0;
        if (ln <= 621) return 1;
        if (ln == 622) return 3;
        return 4;
    endfunction

    task automatic check_point();
        int ln;
        int h;
        int k;
        int eh;
        int el;
        bit s_lo;
        bit p_lo;
        bit act;
        bit v_lo;
        bit fld;
        bit first_eq;
        bit first_br;
        bit mid_e;
        bit mid_b;
        string s_req;
        string a_req;
        ln = int'(line_no);
        h  = int'(hpos);
        if (prev_ok) begin
            eh = (prev_h == L - 1) ? 0 : prev_h + 1;
            el = (prev_h == L - 1) ? ((prev_line == 624) ? 0 : prev_line + 1) : prev_line;
            chk("R1", "clock position", h, eh);
            chk("R1", "line number", ln, el);
        end
        prev_line = ln;
        prev_h = h;
        prev_ok = 1'b1;
        k = kind_of(ln);
        first_eq = h < EQ;
        first_br = h < BR;
        mid_e = (h >= MID) && (h < MID + EQ);
        mid_b = (h >= MID) && (h < MID + BR);
        case (k)
            0, 1, 2: s_lo = h < HS;
            3:       s_lo = (h < HS) || mid_e;
            4:       s_lo = first_eq || mid_e;
            5:       s_lo = first_eq || mid_b;
            6:       s_lo = first_br || mid_b;
            7:       s_lo = first_br || mid_e;
            default: s_lo = first_eq;
        endcase
        if (k <= 2) s_req = "R3";
        else if (k == 3) s_req = (h >= MID) ? "R6" : "R3";
        else if (k == 4 || k == 8) s_req = "R7";
        else s_req = "R8";
        p_lo = (k <= 3) && (h >= HS) && (h < PS);
        case (k)
            1:       act = (h >= PS) && (h < PE);
            2:       act = (h >= LATE) && (h < PE);
            3:       act = (h >= PS) && (h < EARLY);
            default: act = 1'b0;
        endcase
        if (k == 2 || k == 3) a_req = "R6";
        else if (k >= 4) a_req = "R11";
        else a_req = "R5";
        v_lo = (ln == 312 && h >= MID) || ln == 313 || ln == 314 || ln <= 1 ||
               (ln == 2 && h < BR);
        fld = ln <= 312;
        chk(s_req, "csync_n", int'(csync_n), int'(!s_lo));
        chk("R4", "porch_n", int'(porch_n), int'(!p_lo));
        chk(a_req, "pic_active", int'(pic_active), int'(act));
        chk("R9", "vint_n", int'(vint_n), int'(!v_lo));
        chk("R10", "odd_field", int'(odd_field), int'(fld));
    endtask

    // R2: reset hold values and restart at line 5, clock 0
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", "reset csync_n", int'(csync_n), 1);
        chk("R2", "reset vint_n", int'(vint_n), 1);
        chk("R2", "reset porch_n", int'(porch_n), 1);
        chk("R2", "reset pic_active", int'(pic_active), 0);
        chk("R2", "reset odd_field", int'(odd_field), 1);
        chk("R2", "reset line", int'(line_no), 5);
        chk("R2", "reset clock", int'(hpos), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "restart line", int'(line_no), 5);
        chk("R2", "restart clock", int'(hpos), 0);
        chk("R2", "restart csync_n", int'(csync_n), 0);
        chk("R2", "restart porch_n", int'(porch_n), 1);
        prev_line = 5;
        prev_h = 0;
        prev_ok = 1'b1;
    endtask

    // walk and check every clock until the end of line 'last'
    task automatic t_lines(input int first, input int last, input string label);
        int errs_before;
        errs_before = n_errors;
        @(negedge clk);
        chk("R1", {"entry line for ", label}, int'(line_no), first);
        check_point();
        while (!(int'(line_no) == last && int'(hpos) == L - 1)) begin
            @(negedge clk);
            check_point();
        end
        $display("scenario %s: %0d new errors", label, n_errors - errs_before);
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 37; i++) begin
            @(negedge clk);
            check_point();
        end
        t_reset();
    endtask

    initial begin
        t_reset();
        t_lines(5, 21, "first blanking R3 R4 R5");
        t_lines(22, 22, "late half line R6");
        t_lines(23, 309, "first picture R5");
        t_lines(310, 317, "first vertical interval R7 R8 R9 R11");
        t_lines(318, 334, "second blanking R4");
        t_lines(335, 621, "second picture R5");
        t_lines(622, 622, "early half line R6");
        t_lines(623, 4, "second vertical interval and wrap R8 R10");
        t_lines(5, 6, "after wrap R1");
        t_mid_reset();
        t_lines(5, 5, "after mid-line reset R2");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        $display("FAIL R1 watchdog: actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule